// File: doc/BRIEF.md
# Nested Priority Event Controller

This block decides which of sixteen fixed-priority event levels the core should service next. Level 0 ranks highest and level 15 lowest. Level 0 is emulation, 1 is reset, 2 is nonmaskable, 3 is exception, 4 is reserved, 5 is hardware error and 6 is the core timer. Levels 7 to 15 are general-purpose. The block keeps three 16-bit registers in which bit n belongs to level n:
- a capture register records requests that have arrived;
- an enable register selects the levels that may be serviced;
- an active register records every level that is being serviced or is nested under a later one.

When an event is accepted, the block raises a one-cycle take strobe together with the level index. Its active bit sets and its capture bit clears. A return pulse retires the innermost active level, which is the lowest-numbered active bit. That lets waiting events of lower priority through. A group enable gates all general-purpose levels together. Software reaches the registers over a plain register bus that carries a supervisor-mode qualifier.

Top module: `evt_nest_ctrl`

## Requirements
- R1: After reset the capture, enable and active registers read zero and the take strobe is low.
- R2: A high bit on `evt_req` at a clock edge sets the capture bit. At the following edge the event is accepted if it is eligible. `take_vld` is then high for exactly one cycle with `take_vec` equal to the level, the active bit sets and the capture bit clears.
- R3: When several eligible levels are captured, the lowest-numbered one is accepted first.
- R4: A captured level is accepted only if its number is strictly lower than the lowest-numbered active bit. An equal or higher-numbered level waits in the capture register.
- R5: A one-cycle `rfe` pulse clears the lowest-numbered active bit. A level that was waiting may then be accepted at the next edge.
- R6: A level whose enable bit is clear is not accepted, but its capture bit stays set. Setting the enable bit later lets it be accepted. Levels 1 and 2 are always treated as enabled.
- R7: While `gp_en` is low, levels 7 to 15 are not accepted. Levels 0 to 6 are unaffected.
- R8: A bus write to the capture register (address 0) changes only the bits whose enable bit is clear. All other capture bits keep their value.
- R9: The enable register (address 1) is written only when `bus_super` is high. In user mode a write to it is ignored and a read of it returns zero.
- R10: The active register (address 2) is read-only, and writes to it are ignored. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_req | input | 16 | Per-level event request, sampled each edge |
| gp_en | input | 1 | Group enable for levels 7 to 15 |
| rfe | input | 1 | Return-from-event pulse |
| bus_addr | input | 2 | Register select: 0 capture, 1 enable, 2 active |
| bus_wr | input | 1 | Write strobe |
| bus_super | input | 1 | Supervisor-mode qualifier |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| take_vld | output | 1 | One-cycle strobe: an event was accepted |
| take_vec | output | 4 | Level index of the accepted event |

## Verification
The bench sweeps every level on its own and every pair of levels requested together. A controller that mis-ranks levels would accept the wrong member of a pair first. One that compares against the active ceiling with "less or equal" would re-enter a level that is already active. The nesting sweep accepts a lower level, then a higher one on top of it. It then issues returns one by one and checks that an equal-level request waits until the last return. A design that cleared the wrong active bit, or every active bit, would release that request early. Further sweeps cover:
- the forced-enabled levels 1 and 2;
- captures blocked by the group enable;
- capture-register writes that must land only on bits whose enable is clear.

// File: rtl/evt_nest_pkg.sv
package evt_nest_pkg;

    typedef enum logic [1:0] {
        SEL_CAPTURE = 2'd0,
        SEL_ENABLE  = 2'd1,
        SEL_ACTIVE  = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/evt_lowest_pick.sv
module evt_lowest_pick #(
    parameter int unsigned N = 16,
    localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] vec_in,
    output logic [N-1:0] first_oh,
    output logic [W-1:0] first_idx,
    output logic         any_set
);

    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar gi = 0; gi < N; gi++) begin : g_chain
        assign seen[gi+1]   = seen[gi] | vec_in[gi];
        assign first_oh[gi] = vec_in[gi] & ~seen[gi];
    end

    assign any_set = seen[N];

    always_comb begin
        first_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (first_oh[i]) begin
                first_idx = first_idx | W'(i);
            end
        end
    end

endmodule

// File: rtl/evt_take_arb.sv
module evt_take_arb #(
    parameter int unsigned        N        = 16,
    parameter int unsigned        GP_FIRST = 7,
    parameter logic [N-1:0]       FORCED   = 16'h0006,
    localparam int unsigned       W        = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] capture,
    input  logic [N-1:0] enable,
    input  logic [N-1:0] active,
    input  logic         gp_en,
    output logic [N-1:0] take_oh,
    output logic [W-1:0] take_idx,
    output logic         take_any,
    output logic [N-1:0] inner_oh
);

    logic [N-1:0] gp_gate;
    logic [N-1:0] ceiling;
    logic [N-1:0] eligible;
    logic [W-1:0] inner_idx;
    logic         inner_any;

    for (genvar gi = 0; gi < N; gi++) begin : g_gate
        if (gi >= GP_FIRST) begin : g_gp
            assign gp_gate[gi] = gp_en;
        end else begin : g_fixed
            assign gp_gate[gi] = 1'b1;
        end
    end

    evt_lowest_pick #(.N(N)) u_inner (
        .vec_in    (active),
        .first_oh  (inner_oh),
        .first_idx (inner_idx),
        .any_set   (inner_any)
    );

    // Levels strictly above the innermost active one; all levels when idle.
    always_comb begin
        if (inner_any) begin
            ceiling = inner_oh - N'(1);
        end else begin
            ceiling = '1;
        end
        eligible = capture & (enable | FORCED) & gp_gate & ceiling;
    end

    evt_lowest_pick #(.N(N)) u_win (
        .vec_in    (eligible),
        .first_oh  (take_oh),
        .first_idx (take_idx),
        .any_set   (take_any)
    );

    logic unused_ok;
    assign unused_ok = ^inner_idx;

endmodule

// File: rtl/evt_nest_ctrl.sv
module evt_nest_ctrl #(
    parameter int unsigned  LVL_N    = 16,
    parameter int unsigned  GP_FIRST = 7,
    parameter logic [15:0]  FORCED   = 16'h0006,
    localparam int unsigned LVL_W    = $clog2(LVL_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_N-1:0] evt_req,
    input  logic             gp_en,
    input  logic             rfe,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_super,
    input  logic [LVL_N-1:0] bus_wdata,
    output logic [LVL_N-1:0] bus_rdata,
    output logic             take_vld,
    output logic [LVL_W-1:0] take_vec
);
    import evt_nest_pkg::*;

    typedef struct packed {
        logic [LVL_N-1:0] capture;
        logic [LVL_N-1:0] enable;
        logic [LVL_N-1:0] active;
        logic             take;
        logic [LVL_W-1:0] vec;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic [LVL_N-1:0] take_oh;
    logic [LVL_W-1:0] take_idx;
    logic             take_any;
    logic [LVL_N-1:0] inner_oh;

    evt_take_arb #(
        .N        (LVL_N),
        .GP_FIRST (GP_FIRST),
        .FORCED   (FORCED[LVL_N-1:0])
    ) u_arb (
        .capture  (st_q.capture),
        .enable   (st_q.enable),
        .active   (st_q.active),
        .gp_en    (gp_en),
        .take_oh  (take_oh),
        .take_idx (take_idx),
        .take_any (take_any),
        .inner_oh (inner_oh)
    );

    reg_sel_e         sel;
    logic [LVL_N-1:0] sw_lane;
    logic [LVL_N-1:0] cap_sw;
    logic [LVL_N-1:0] retire;

    always_comb begin
        sel     = reg_sel_e'(bus_addr);
        st_d    = st_q;

        sw_lane = (bus_wr && sel == SEL_CAPTURE) ? ~st_q.enable : '0;
        cap_sw  = (st_q.capture & ~sw_lane) | (bus_wdata & sw_lane);
        st_d.capture = (cap_sw & ~take_oh) | evt_req;

        if (bus_wr && bus_super && sel == SEL_ENABLE) begin
            st_d.enable = bus_wdata;
        end

        retire      = rfe ? inner_oh : '0;
        st_d.active = (st_q.active & ~retire) | take_oh;

        st_d.take = take_any;
        st_d.vec  = take_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (sel)
            SEL_CAPTURE: bus_rdata = st_q.capture;
            SEL_ENABLE:  bus_rdata = bus_super ? st_q.enable : '0;
            SEL_ACTIVE:  bus_rdata = st_q.active;
            default:     bus_rdata = '0;
        endcase
    end

    assign take_vld = st_q.take;
    assign take_vec = st_q.vec;

endmodule

// File: rtl/evt_nest_chk.sv
module evt_nest_chk #(
    parameter int unsigned N        = 16,
    parameter int unsigned W        = 4,
    parameter int unsigned GP_FIRST = 7
) (
    input logic         clk,
    input logic         rst_n,
    input logic         take_vld,
    input logic [W-1:0] take_vec,
    input logic [N-1:0] capture_q,
    input logic [N-1:0] enable_q,
    input logic [N-1:0] active_q,
    input logic         rfe,
    input logic         gp_en,
    input logic         bus_wr,
    input logic         bus_super
);

    logic [N-1:0] prev_cap;
    logic [N-1:0] prev_act;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_cap <= '0;
            prev_act <= '0;
        end else begin
            prev_cap <= capture_q;
            prev_act <= active_q;
        end
    end

    function automatic logic [N-1:0] upto(input logic [W-1:0] v);
        logic [N-1:0] ones;
        ones = '1;
        return ~(ones << (32'(v) + 1));
    endfunction

    AST_TAKE_MARKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        take_vld |-> active_q[take_vec]); // R2

    AST_TAKE_WAS_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        take_vld |-> prev_cap[take_vec]); // R2

    AST_TAKE_OUTRANKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        take_vld |-> ((prev_act & upto(take_vec)) == '0)); // R4

    AST_ACTIVE_GROWS_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(active_q) > $countones(prev_act)) |-> take_vld); // R4

    AST_RETURN_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rfe) && !take_vld && prev_act != '0)
            |-> ($countones(active_q) + 1 == $countones(prev_act))); // R5

    AST_GROUP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_vld && 32'(take_vec) >= GP_FIRST) |-> $past(gp_en)); // R7

    AST_USER_ENABLE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_super) |=> $stable(enable_q)); // R9

endmodule

bind evt_nest_ctrl evt_nest_chk #(
    .N        (LVL_N),
    .W        (LVL_W),
    .GP_FIRST (GP_FIRST)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_vld  (take_vld),
    .take_vec  (take_vec),
    .capture_q (st_q.capture),
    .enable_q  (st_q.enable),
    .active_q  (st_q.active),
    .rfe       (rfe),
    .gp_en     (gp_en),
    .bus_wr    (bus_wr),
    .bus_super (bus_super)
);

// File: tb/evt_nest_ctrl_tb.sv
module evt_nest_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] evt_req;
    logic        gp_en;
    logic        rfe;
    logic [1:0]  bus_addr;
    logic        bus_wr;
    logic        bus_super;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        take_vld;
    logic [3:0]  take_vec;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_nest_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_req   (evt_req),
        .gp_en     (gp_en),
        .rfe       (rfe),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_super (bus_super),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .take_vld  (take_vld),
        .take_vec  (take_vec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; evt_req = '0; gp_en = 1'b0; rfe = 1'b0;
        bus_addr = '0; bus_wr = 1'b0; bus_super = 1'b0; bus_wdata = '0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d, input logic sup);
        bus_addr = a; bus_wdata = d; bus_super = sup; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic sup, output logic [15:0] d);
        bus_addr = a; bus_super = sup;
        #1;
        d = bus_rdata;
    endtask

    task automatic init(input logic [15:0] en, input logic g);
        do_reset();
        bus_write(2'd1, en, 1'b1);
        gp_en = g;
    endtask

    task automatic pulse_req(input logic [15:0] v);
        evt_req = v;
        step();
        evt_req = '0;
    endtask

    task automatic pulse_rfe();
        rfe = 1'b1;
        step();
        rfe = 1'b0;
    endtask

    task automatic chk_take(input string tag, input int lvl);
        chk(tag, {31'd0, take_vld}, 32'd1);
        chk(tag, {28'd0, take_vec}, lvl[31:0]);
    endtask

    initial begin
        logic [15:0] rd;

        // R1 reset state, R10 unused address
        do_reset();
        chk("R1 take", {31'd0, take_vld}, 32'd0);
        bus_read(2'd0, 1'b1, rd); chk("R1 capture", {16'd0, rd}, 32'd0);
        bus_read(2'd1, 1'b1, rd); chk("R1 enable", {16'd0, rd}, 32'd0);
        bus_read(2'd2, 1'b1, rd); chk("R1 active", {16'd0, rd}, 32'd0);
        bus_read(2'd3, 1'b1, rd); chk("R10 addr3", {16'd0, rd}, 32'd0);

        // R2 single levels, R5 return, R10 active write ignored
        for (int n = 0; n < 16; n++) begin
            init(16'hFFFF, 1'b1);
            pulse_req(16'(1) << n);
            bus_read(2'd0, 1'b0, rd); chk("R2 captured", {16'd0, rd}, 32'(16'(1) << n));
            step();
            chk_take("R2 accept", n);
            bus_read(2'd2, 1'b0, rd); chk("R2 active set", {16'd0, rd}, 32'(16'(1) << n));
            bus_read(2'd0, 1'b0, rd); chk("R2 capture clr", {16'd0, rd}, 32'd0);
            bus_write(2'd2, 16'h0000, 1'b1);
            chk("R2 one-cycle strobe", {31'd0, take_vld}, 32'd0);
            bus_read(2'd2, 1'b0, rd); chk("R10 active ro", {16'd0, rd}, 32'(16'(1) << n));
            pulse_rfe();
            bus_read(2'd2, 1'b0, rd); chk("R5 retired", {16'd0, rd}, 32'd0);
        end

        // R3 simultaneous pairs, R4 block, R5 release
        for (int a = 0; a < 16; a++) begin
            for (int b = a + 1; b < 16; b++) begin
                init(16'hFFFF, 1'b1);
                pulse_req((16'(1) << a) | (16'(1) << b));
                step();
                chk_take("R3 lowest first", a);
                step();
                chk("R4 higher blocked", {31'd0, take_vld}, 32'd0);
                bus_read(2'd0, 1'b0, rd); chk("R4 still captured", {16'd0, rd}, 32'(16'(1) << b));
                pulse_rfe();
                chk("R5 none at return", {31'd0, take_vld}, 32'd0);
                step();
                chk_take("R5 released", b);
            end
        end

        // R4 nesting and equal-level wait, R5 innermost retire
        for (int a = 0; a < 16; a++) begin
            for (int b = a + 1; b < 16; b++) begin
                init(16'hFFFF, 1'b1);
                pulse_req(16'(1) << b);
                step();
                chk_take("R4 outer", b);
                pulse_req(16'(1) << a);
                step();
                chk_take("R4 nested", a);
                bus_read(2'd2, 1'b0, rd);
                chk("R4 both active", {16'd0, rd}, 32'((16'(1) << a) | (16'(1) << b)));
                pulse_req(16'(1) << b);
                step();
                chk("R4 equal waits", {31'd0, take_vld}, 32'd0);
                pulse_rfe();
                bus_read(2'd2, 1'b0, rd); chk("R5 inner retired", {16'd0, rd}, 32'(16'(1) << b));
                step();
                chk("R4 equal to ceiling", {31'd0, take_vld}, 32'd0);
                pulse_rfe();
                step();
                chk_take("R5 re-enter", b);
            end
        end

        // R6 disabled levels hold, forced levels 1 and 2
        for (int n = 0; n < 16; n++) begin
            init(16'h0000, 1'b1);
            pulse_req(16'(1) << n);
            step();
            if (n == 1 || n == 2) begin
                chk_take("R6 forced on", n);
            end else begin
                chk("R6 disabled", {31'd0, take_vld}, 32'd0);
                bus_read(2'd0, 1'b0, rd); chk("R6 held", {16'd0, rd}, 32'(16'(1) << n));
                bus_write(2'd1, 16'(1) << n, 1'b1);
                chk("R6 not yet", {31'd0, take_vld}, 32'd0);
                step();
                chk_take("R6 enabled later", n);
            end
        end

        // R8 capture writes land only where enable is clear
        init(16'h00F0, 1'b0);
        bus_write(2'd0, 16'hFFF9, 1'b1);
        bus_read(2'd0, 1'b0, rd); chk("R8 masked write", {16'd0, rd}, 32'h0000FF09);
        step();
        chk("R8 no take", {31'd0, take_vld}, 32'd0);
        for (int n = 0; n < 16; n++) begin
            init(16'hFFFF ^ (16'(1) << n), 1'b1);
            bus_write(2'd0, 16'hFFFF, 1'b0);
            bus_read(2'd0, 1'b0, rd); chk("R8 single lane", {16'd0, rd}, 32'(16'(1) << n));
            step();
            if (n == 1 || n == 2) begin
                chk_take("R8 forced take", n);
            end else begin
                chk("R8 idle", {31'd0, take_vld}, 32'd0);
                bus_write(2'd0, 16'h0000, 1'b0);
                bus_read(2'd0, 1'b0, rd); chk("R8 cleared", {16'd0, rd}, 32'd0);
            end
        end

        // R7 group enable
        init(16'hFFFF, 1'b0);
        for (int n = 7; n < 16; n++) begin
            pulse_req(16'(1) << n);
            step();
            chk("R7 gated", {31'd0, take_vld}, 32'd0);
        end
        bus_read(2'd0, 1'b0, rd); chk("R7 captured", {16'd0, rd}, 32'h0000FF80);
        pulse_req(16'h0040);
        step();
        chk_take("R7 level6 open", 6);
        pulse_rfe();
        gp_en = 1'b1;
        step();
        chk_take("R7 reopened", 7);

        // R9 supervisor qualifier
        init(16'h0000, 1'b1);
        bus_write(2'd1, 16'h1234, 1'b0);
        bus_read(2'd1, 1'b1, rd); chk("R9 user write", {16'd0, rd}, 32'd0);
        bus_write(2'd1, 16'h1234, 1'b1);
        bus_read(2'd1, 1'b0, rd); chk("R9 user read", {16'd0, rd}, 32'd0);
        bus_read(2'd1, 1'b1, rd); chk("R9 super read", {16'd0, rd}, 32'h00001234);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule